// File: doc/BRIEF.md
# Translation Fault Diagnostic Capture

This block records the diagnostic context of an address translation fault so that the miss-handling firmware can service it. On a data-side fault, it stores the faulting virtual address. It also stores a status word built from fields of the faulting instruction and the access flags. A third register gets the address of the page-table entry that maps the faulting page. On an instruction-side fault, it stores the faulting PC and the page-table-entry address for that PC.

Each side has its own page-table base register, which firmware programs. The entry address is formed by OR-ing the virtual page number, shifted left by three, into that base. A capture is skipped for speculative accesses. On the data side, it is also skipped for page-table-entry loads and for accesses that carry a no-fault qualifier. The registers are never locked: each qualifying fault overwrites the previous contents. A combinational handoff strobe per side marks the cycle in which the fault is accepted. A single register read and write port gives firmware access to all registers.

Top module: `fcap_unit`

## Requirements
- R1: After synchronous reset, every register reads zero: the fault address, status word, both entry addresses, the instruction tag and both page-table bases.
- R2: A data fault is accepted when `dfault_valid` is high and `dfault_misspec`, `dfault_pte_load` and `dfault_nofault` are all low. On the next clock edge, `fault_va` takes `dfault_va`.
- R3: On an accepted data fault, `mm_stat` takes the following values. Bits 16:11 take instruction bits 31:26. Bits 10:6 take instruction bits 25:21. Bits 5:0 take `dfault_flags`.
- R4: On an accepted data fault, `dform` takes the data page-table base OR ((`dfault_va` >> 13) << 3).
- R5: A data fault with any of `dfault_misspec`, `dfault_pte_load` or `dfault_nofault` high leaves `fault_va`, `mm_stat` and `dform` unchanged.
- R6: The registers are not locked. A later accepted fault overwrites the values of an earlier one even if firmware never read them.
- R7: An instruction fault is accepted when `ifault_valid` is high and `ifault_misspec` is low. On the next edge, `itag` takes `ifault_pc` and `iform` takes the instruction base OR ((`ifault_pc` >> 13) << 3). A misspeculated instruction fault leaves both unchanged.
- R8: With `reg_we` high, select 3 writes the data page-table base and select 6 writes the instruction page-table base. Writes to any other select are ignored.
- R9: `reg_rdata` is combinational from `reg_sel`, zero-extended where needed. The select codes are: 0 fault address, 1 status word, 2 data entry address, 3 data base, 4 instruction tag, 5 instruction entry address, 6 instruction base, 7 reads zero.
- R10: `dcap_o` and `icap_o` are high in exactly the cycles in which a data fault or an instruction fault, respectively, is accepted.
- R11: When a base write and a fault on the same side occur in the same cycle, the entry address is formed from the base value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dfault_valid | input | 1 | Data translation fault presented |
| dfault_va | input | ADDR_W | Faulting data virtual address |
| dfault_inst | input | 32 | Faulting instruction word |
| dfault_flags | input | 6 | Access flag bits |
| dfault_misspec | input | 1 | Access is misspeculated |
| dfault_pte_load | input | 1 | Access is a page-table-entry load |
| dfault_nofault | input | 1 | Access carries the no-fault qualifier |
| ifault_valid | input | 1 | Instruction translation fault presented |
| ifault_pc | input | ADDR_W | Faulting PC |
| ifault_misspec | input | 1 | Instruction fetch is misspeculated |
| reg_we | input | 1 | Firmware register write enable |
| reg_sel | input | 3 | Firmware register select |
| reg_wdata | input | ADDR_W | Firmware write data |
| reg_rdata | output | ADDR_W | Firmware read data |
| dcap_o | output | 1 | Data fault accepted this cycle |
| icap_o | output | 1 | Instruction fault accepted this cycle |
| fault_va | output | ADDR_W | Captured data fault address |
| mm_stat | output | 17 | Captured status word |
| dform | output | ADDR_W | Data-side page-table-entry address |
| itag | output | ADDR_W | Captured instruction fault PC |
| iform | output | ADDR_W | Instruction-side page-table-entry address |

## Verification
The assertions check the following on every cycle:
- an accepted data fault loads the address and the status fields;
- an accepted instruction fault loads the tag;
- a suppressed or misspeculated fault leaves the captured registers frozen;
- the base registers hold whenever no write is issued.

Some behaviours can only be shown by the bench scenarios:
- the formatted entry-address arithmetic;
- the overwrite of registers that were never read;
- the use of the old base during a concurrent write;
- the read-select decoding and the ignored writes.

The randomized run compares every register against a bench model on each cycle.

// File: rtl/fcap_pkg.sv
package fcap_pkg;

    localparam int INST_W  = 32;
    localparam int FLAG_W  = 6;
    localparam int OPC_W   = 6;
    localparam int RA_W    = 5;
    localparam int OPC_LSB = 26;
    localparam int RA_LSB  = 21;
    localparam int STAT_W  = OPC_W + RA_W + FLAG_W;
    localparam int SEL_W   = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_FVA   = 3'd0,
        SEL_STAT  = 3'd1,
        SEL_DFORM = 3'd2,
        SEL_DPTB  = 3'd3,
        SEL_ITAG  = 3'd4,
        SEL_IFORM = 3'd5,
        SEL_IPTB  = 3'd6,
        SEL_NONE  = 3'd7
    } reg_sel_e;

    // Packed MSB first: opcode 16:11, register field 10:6, flags 5:0
    typedef struct packed {
        logic [OPC_W-1:0]  opcode;
        logic [RA_W-1:0]   ra;
        logic [FLAG_W-1:0] flags;
    } mm_stat_t;

    function automatic mm_stat_t pack_stat(input logic [INST_W-1:0] inst,
                                           input logic [FLAG_W-1:0] fl);
        mm_stat_t s;
        s.opcode = inst[OPC_LSB +: OPC_W];
        s.ra     = inst[RA_LSB +: RA_W];
        s.flags  = fl;
        return s;
    endfunction

endpackage

// File: rtl/fcap_form.sv
module fcap_form #(
    parameter int ADDR_W     = 64,
    parameter int PAGE_SHIFT = 13,
    parameter int PTE_SHIFT  = 3
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] va_i,
    output logic [ADDR_W-1:0] form_o
);
    logic [ADDR_W-1:0] vpn;

    always_comb begin
        vpn    = va_i >> PAGE_SHIFT;
        form_o = base_i | (vpn << PTE_SHIFT);
    end
endmodule

// File: rtl/fcap_ptb_regs.sv
module fcap_ptb_regs #(
    parameter int ADDR_W = 64
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we_i,
    input  logic [fcap_pkg::SEL_W-1:0] sel_i,
    input  logic [ADDR_W-1:0]        wdata_i,
    output logic [ADDR_W-1:0]        dptb_o,
    output logic [ADDR_W-1:0]        iptb_o
);
    import fcap_pkg::*;

    localparam int NBASE = 2;

    logic [ADDR_W-1:0] base_q [NBASE];

    for (genvar g = 0; g < NBASE; g++) begin : g_base
        localparam logic [SEL_W-1:0] CODE = (g == 0) ? SEL_DPTB : SEL_IPTB;
        always_ff @(posedge clk) begin
            if (rst)
                base_q[g] <= '0;
            else if (we_i && (sel_i == CODE))
                base_q[g] <= wdata_i;
        end
    end

    assign dptb_o = base_q[0];
    assign iptb_o = base_q[1];
endmodule

// File: rtl/fcap_dside.sv
module fcap_dside #(
    parameter int ADDR_W     = 64,
    parameter int PAGE_SHIFT = 13,
    parameter int PTE_SHIFT  = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cap_i,
    input  logic [ADDR_W-1:0]             va_i,
    input  logic [fcap_pkg::INST_W-1:0]   inst_i,
    input  logic [fcap_pkg::FLAG_W-1:0]   flags_i,
    input  logic [ADDR_W-1:0]             base_i,
    output logic [ADDR_W-1:0]             va_o,
    output logic [fcap_pkg::STAT_W-1:0]   stat_o,
    output logic [ADDR_W-1:0]             form_o
);
    import fcap_pkg::*;

    logic [ADDR_W-1:0] va_q;
    logic [ADDR_W-1:0] form_q;
    logic [ADDR_W-1:0] form_d;
    mm_stat_t          stat_q;

    fcap_form #(
        .ADDR_W    (ADDR_W),
        .PAGE_SHIFT(PAGE_SHIFT),
        .PTE_SHIFT (PTE_SHIFT)
    ) u_form (
        .base_i(base_i),
        .va_i  (va_i),
        .form_o(form_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            va_q   <= '0;
            stat_q <= '0;
            form_q <= '0;
        end else if (cap_i) begin
            va_q   <= va_i;
            stat_q <= pack_stat(inst_i, flags_i);
            form_q <= form_d;
        end
    end

    assign va_o   = va_q;
    assign stat_o = stat_q;
    assign form_o = form_q;
endmodule

// File: rtl/fcap_iside.sv
module fcap_iside #(
    parameter int ADDR_W     = 64,
    parameter int PAGE_SHIFT = 13,
    parameter int PTE_SHIFT  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic [ADDR_W-1:0] tag_o,
    output logic [ADDR_W-1:0] form_o
);
    logic [ADDR_W-1:0] tag_q;
    logic [ADDR_W-1:0] form_q;
    logic [ADDR_W-1:0] form_d;

    fcap_form #(
        .ADDR_W    (ADDR_W),
        .PAGE_SHIFT(PAGE_SHIFT),
        .PTE_SHIFT (PTE_SHIFT)
    ) u_form (
        .base_i(base_i),
        .va_i  (pc_i),
        .form_o(form_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q  <= '0;
            form_q <= '0;
        end else if (cap_i) begin
            tag_q  <= pc_i;
            form_q <= form_d;
        end
    end

    assign tag_o  = tag_q;
    assign form_o = form_q;
endmodule

// File: rtl/fcap_unit.sv
module fcap_unit #(
    parameter int ADDR_W     = 64,
    parameter int PAGE_SHIFT = 13,
    parameter int PTE_SHIFT  = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          dfault_valid,
    input  logic [ADDR_W-1:0]             dfault_va,
    input  logic [fcap_pkg::INST_W-1:0]   dfault_inst,
    input  logic [fcap_pkg::FLAG_W-1:0]   dfault_flags,
    input  logic                          dfault_misspec,
    input  logic                          dfault_pte_load,
    input  logic                          dfault_nofault,
    input  logic                          ifault_valid,
    input  logic [ADDR_W-1:0]             ifault_pc,
    input  logic                          ifault_misspec,
    input  logic                          reg_we,
    input  logic [fcap_pkg::SEL_W-1:0]    reg_sel,
    input  logic [ADDR_W-1:0]             reg_wdata,
    output logic [ADDR_W-1:0]             reg_rdata,
    output logic                          dcap_o,
    output logic                          icap_o,
    output logic [ADDR_W-1:0]             fault_va,
    output logic [fcap_pkg::STAT_W-1:0]   mm_stat,
    output logic [ADDR_W-1:0]             dform,
    output logic [ADDR_W-1:0]             itag,
    output logic [ADDR_W-1:0]             iform
);
    import fcap_pkg::*;

    localparam int PAD_W = ADDR_W - STAT_W;

    logic [ADDR_W-1:0] dptb_q;
    logic [ADDR_W-1:0] iptb_q;
    logic              d_blocked;

    // Data capture is held off for speculative, entry-load and no-fault accesses
    assign d_blocked = dfault_misspec | dfault_pte_load | dfault_nofault;
    assign dcap_o    = dfault_valid & ~d_blocked;
    assign icap_o    = ifault_valid & ~ifault_misspec;

    fcap_ptb_regs #(.ADDR_W(ADDR_W)) u_ptb (
        .clk    (clk),
        .rst    (rst),
        .we_i   (reg_we),
        .sel_i  (reg_sel),
        .wdata_i(reg_wdata),
        .dptb_o (dptb_q),
        .iptb_o (iptb_q)
    );

    fcap_dside #(
        .ADDR_W    (ADDR_W),
        .PAGE_SHIFT(PAGE_SHIFT),
        .PTE_SHIFT (PTE_SHIFT)
    ) u_dside (
        .clk    (clk),
        .rst    (rst),
        .cap_i  (dcap_o),
        .va_i   (dfault_va),
        .inst_i (dfault_inst),
        .flags_i(dfault_flags),
        .base_i (dptb_q),
        .va_o   (fault_va),
        .stat_o (mm_stat),
        .form_o (dform)
    );

    fcap_iside #(
        .ADDR_W    (ADDR_W),
        .PAGE_SHIFT(PAGE_SHIFT),
        .PTE_SHIFT (PTE_SHIFT)
    ) u_iside (
        .clk   (clk),
        .rst   (rst),
        .cap_i (icap_o),
        .pc_i  (ifault_pc),
        .base_i(iptb_q),
        .tag_o (itag),
        .form_o(iform)
    );

    always_comb begin
        case (reg_sel_e'(reg_sel))
            SEL_FVA:   reg_rdata = fault_va;
            SEL_STAT:  reg_rdata = {{PAD_W{1'b0}}, mm_stat};
            SEL_DFORM: reg_rdata = dform;
            SEL_DPTB:  reg_rdata = dptb_q;
            SEL_ITAG:  reg_rdata = itag;
            SEL_IFORM: reg_rdata = iform;
            SEL_IPTB:  reg_rdata = iptb_q;
            default:   reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/fcap_unit_chk.sv
module fcap_unit_chk #(
    parameter int ADDR_W = 64
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        dfault_valid,
    input logic [ADDR_W-1:0]           dfault_va,
    input logic [fcap_pkg::INST_W-1:0] dfault_inst,
    input logic [fcap_pkg::FLAG_W-1:0] dfault_flags,
    input logic                        dfault_misspec,
    input logic                        dfault_pte_load,
    input logic                        dfault_nofault,
    input logic                        ifault_valid,
    input logic [ADDR_W-1:0]           ifault_pc,
    input logic                        ifault_misspec,
    input logic                        reg_we,
    input logic                        dcap_o,
    input logic                        icap_o,
    input logic [ADDR_W-1:0]           fault_va,
    input logic [fcap_pkg::STAT_W-1:0] mm_stat,
    input logic [ADDR_W-1:0]           dform,
    input logic [ADDR_W-1:0]           itag,
    input logic [ADDR_W-1:0]           iform,
    input logic [ADDR_W-1:0]           dptb_q,
    input logic [ADDR_W-1:0]           iptb_q
);
    // R2
    fva_capture_chk: assert property (@(posedge clk) disable iff (rst)
        dcap_o |=> fault_va == $past(dfault_va));

    // R3
    stat_fields_chk: assert property (@(posedge clk) disable iff (rst)
        dcap_o |=> (mm_stat[5:0] == $past(dfault_flags)) &&
                   (mm_stat[16:11] == $past(dfault_inst[31:26])) &&
                   (mm_stat[10:6] == $past(dfault_inst[25:21])));

    // R5
    dsuppress_chk: assert property (@(posedge clk) disable iff (rst)
        (dfault_valid && (dfault_misspec || dfault_pte_load || dfault_nofault))
        |=> $stable(fault_va) && $stable(mm_stat) && $stable(dform));

    // R7
    itag_capture_chk: assert property (@(posedge clk) disable iff (rst)
        icap_o |=> itag == $past(ifault_pc));

    // R7
    imisspec_chk: assert property (@(posedge clk) disable iff (rst)
        (ifault_valid && ifault_misspec) |=> $stable(itag) && $stable(iform));

    // R8
    base_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !reg_we |=> $stable(dptb_q) && $stable(iptb_q));

    // R10
    strobe_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !dfault_valid |-> !dcap_o);
endmodule

bind fcap_unit fcap_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .dfault_valid   (dfault_valid),
    .dfault_va      (dfault_va),
    .dfault_inst    (dfault_inst),
    .dfault_flags   (dfault_flags),
    .dfault_misspec (dfault_misspec),
    .dfault_pte_load(dfault_pte_load),
    .dfault_nofault (dfault_nofault),
    .ifault_valid   (ifault_valid),
    .ifault_pc      (ifault_pc),
    .ifault_misspec (ifault_misspec),
    .reg_we         (reg_we),
    .dcap_o         (dcap_o),
    .icap_o         (icap_o),
    .fault_va       (fault_va),
    .mm_stat        (mm_stat),
    .dform          (dform),
    .itag           (itag),
    .iform          (iform),
    .dptb_q         (dptb_q),
    .iptb_q         (iptb_q)
);

// File: tb/fcap_unit_test.sv
module fcap_unit_test;
    localparam int AW = 64;

    logic          clk = 1'b0;
    logic          rst;
    logic          dfault_valid, dfault_misspec, dfault_pte_load, dfault_nofault;
    logic [AW-1:0] dfault_va;
    logic [31:0]   dfault_inst;
    logic [5:0]    dfault_flags;
    logic          ifault_valid, ifault_misspec;
    logic [AW-1:0] ifault_pc;
    logic          reg_we;
    logic [2:0]    reg_sel;
    logic [AW-1:0] reg_wdata;
    logic [AW-1:0] reg_rdata;
    logic          dcap_o, icap_o;
    logic [AW-1:0] fault_va, dform, itag, iform;
    logic [16:0]   mm_stat;

    int checks = 0;
    int errors = 0;

    // bench model
    logic [AW-1:0] m_fva, m_dform, m_itag, m_iform, m_dptb, m_iptb;
    logic [16:0]   m_stat;

    fcap_unit uut (
        .clk(clk), .rst(rst),
        .dfault_valid(dfault_valid), .dfault_va(dfault_va),
        .dfault_inst(dfault_inst), .dfault_flags(dfault_flags),
        .dfault_misspec(dfault_misspec), .dfault_pte_load(dfault_pte_load),
        .dfault_nofault(dfault_nofault),
        .ifault_valid(ifault_valid), .ifault_pc(ifault_pc),
        .ifault_misspec(ifault_misspec),
        .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .dcap_o(dcap_o), .icap_o(icap_o),
        .fault_va(fault_va), .mm_stat(mm_stat), .dform(dform),
        .itag(itag), .iform(iform)
    );

    always #10 clk = ~clk;

    function automatic logic [16:0] exp_stat(input logic [31:0] inst,
                                             input logic [5:0] fl);
        return {inst[31:26], inst[25:21], fl};
    endfunction

    function automatic logic [AW-1:0] exp_form(input logic [AW-1:0] base,
                                               input logic [AW-1:0] va);
        return base | ((va >> 13) << 3);
    endfunction

    function automatic logic [AW-1:0] exp_read(input logic [2:0] s);
        case (s)
            3'd0: return m_fva;
            3'd1: return {47'd0, m_stat};
            3'd2: return m_dform;
            3'd3: return m_dptb;
            3'd4: return m_itag;
            3'd5: return m_iform;
            3'd6: return m_iptb;
            default: return '0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        dfault_valid = 0; dfault_misspec = 0; dfault_pte_load = 0; dfault_nofault = 0;
        dfault_va = '0; dfault_inst = '0; dfault_flags = '0;
        ifault_valid = 0; ifault_misspec = 0; ifault_pc = '0;
        reg_we = 0; reg_sel = 3'd0; reg_wdata = '0;
    endtask

    task automatic check_outputs();
        chk("R2 fault_va", fault_va, m_fva);
        chk("R3 mm_stat", {47'd0, mm_stat}, {47'd0, m_stat});
        chk("R4 dform", dform, m_dform);
        chk("R7 itag", itag, m_itag);
        chk("R7 iform", iform, m_iform);
    endtask

    // Inputs are set just after a falling edge; runs one clock and checks.
    task automatic step();
        logic dacc, iacc;
        #1;
        dacc = dfault_valid && !dfault_misspec && !dfault_pte_load && !dfault_nofault;
        iacc = ifault_valid && !ifault_misspec;
        chk("R10 dcap_o", {63'd0, dcap_o}, {63'd0, dacc});
        chk("R10 icap_o", {63'd0, icap_o}, {63'd0, iacc});
        chk("R9 reg_rdata", reg_rdata, exp_read(reg_sel));
        if (dacc) begin
            m_fva   = dfault_va;
            m_stat  = exp_stat(dfault_inst, dfault_flags);
            m_dform = exp_form(m_dptb, dfault_va);
        end
        if (iacc) begin
            m_itag  = ifault_pc;
            m_iform = exp_form(m_iptb, ifault_pc);
        end
        if (reg_we && reg_sel == 3'd3) m_dptb = reg_wdata;
        if (reg_we && reg_sel == 3'd6) m_iptb = reg_wdata;
        @(posedge clk);
        @(negedge clk);
        check_outputs();
    endtask

    task automatic read_reg(input logic [2:0] s, input string tag,
                            input logic [AW-1:0] exp);
        reg_sel = s;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [AW-1:0] old;
        void'($urandom(32'd4711));
        idle_inputs();
        rst = 1;
        m_fva = '0; m_stat = '0; m_dform = '0; m_itag = '0; m_iform = '0;
        m_dptb = '0; m_iptb = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1 reset state through every select
        for (int s = 0; s < 8; s++) read_reg(3'(s), "R1 reset read", '0);
        chk("R1 fault_va", fault_va, '0);
        chk("R1 mm_stat", {47'd0, mm_stat}, '0);

        // R8 program both bases
        reg_we = 1; reg_sel = 3'd3; reg_wdata = 64'hFFFF_0000_0000_0000; step();
        reg_sel = 3'd6; reg_wdata = 64'h8000_0000_0000_0000; step();
        reg_we = 0;
        read_reg(3'd3, "R8 dptb write", 64'hFFFF_0000_0000_0000);
        read_reg(3'd6, "R8 iptb write", 64'h8000_0000_0000_0000);

        // R8 writes to read-only selects are ignored
        for (int s = 0; s < 8; s++) begin
            if (s != 3 && s != 6) begin
                reg_we = 1; reg_sel = 3'(s); reg_wdata = 64'hDEAD_BEEF_DEAD_BEEF; step();
            end
        end
        reg_we = 0;
        read_reg(3'd0, "R8 ignored write fva", '0);
        read_reg(3'd4, "R8 ignored write itag", '0);
        read_reg(3'd7, "R8 ignored write sel7", '0);

        // R2 R3 R4 accepted data fault
        dfault_valid = 1; dfault_va = 64'h0000_1234_5678_A000;
        dfault_inst = 32'hA43F_0000; dfault_flags = 6'h2A; step();
        chk("R3 stat directed", {47'd0, mm_stat},
            {47'd0, 6'h29, 5'h01, 6'h2A});
        chk("R4 dform directed", dform,
            64'hFFFF_0000_0000_0000 | ((64'h0000_1234_5678_A000 >> 13) << 3));
        read_reg(3'd1, "R9 stat read", {47'd0, 6'h29, 5'h01, 6'h2A});

        // R5 each suppressing qualifier
        old = fault_va;
        dfault_va = 64'h1111; dfault_misspec = 1; step(); dfault_misspec = 0;
        chk("R5 misspec ignored", fault_va, old);
        dfault_va = 64'h2222; dfault_pte_load = 1; step(); dfault_pte_load = 0;
        chk("R5 pte load ignored", fault_va, old);
        dfault_va = 64'h3333; dfault_nofault = 1; step(); dfault_nofault = 0;
        chk("R5 nofault ignored", fault_va, old);

        // R6 back-to-back faults overwrite without a read
        dfault_va = 64'hAAAA_0000; dfault_flags = 6'h01; step();
        dfault_va = 64'hBBBB_0000; dfault_flags = 6'h3F; step();
        chk("R6 overwrite", fault_va, 64'hBBBB_0000);
        dfault_valid = 0;

        // R7 instruction fault, then a misspeculated one
        ifault_valid = 1; ifault_pc = 64'h0000_0000_0040_2004; step();
        chk("R7 iform directed", iform,
            64'h8000_0000_0000_0000 | ((64'h0000_0000_0040_2004 >> 13) << 3));
        ifault_misspec = 1; ifault_pc = 64'h7777_0000; step();
        chk("R7 misspec ignored", itag, 64'h0000_0000_0040_2004);
        ifault_valid = 0; ifault_misspec = 0;

        // R11 base write concurrent with a data fault uses the old base
        reg_we = 1; reg_sel = 3'd3; reg_wdata = 64'h0000_00FF_0000_0000;
        dfault_valid = 1; dfault_va = 64'h0000_0000_0100_0000; step();
        reg_we = 0; dfault_valid = 0;
        chk("R11 old base used", dform,
            64'hFFFF_0000_0000_0000 | ((64'h0000_0000_0100_0000 >> 13) << 3));
        read_reg(3'd3, "R11 new base held", 64'h0000_00FF_0000_0000);

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            dfault_valid    = $urandom_range(0, 1) == 1;
            dfault_misspec  = $urandom_range(0, 3) == 0;
            dfault_pte_load = $urandom_range(0, 3) == 0;
            dfault_nofault  = $urandom_range(0, 3) == 0;
            dfault_va       = {$urandom, $urandom};
            dfault_inst     = $urandom;
            dfault_flags    = 6'($urandom);
            ifault_valid    = $urandom_range(0, 1) == 1;
            ifault_misspec  = $urandom_range(0, 3) == 0;
            ifault_pc       = {$urandom, $urandom};
            reg_we          = $urandom_range(0, 5) == 0;
            reg_sel         = 3'($urandom);
            reg_wdata       = {$urandom, $urandom};
            step();
        end
        idle_inputs();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule